// File: doc/BRIEF.md
# In-Place Exchange Sorter

This block holds a small table of unsigned words in an internal single-port memory and puts them into ascending order where they sit. It has two phases, and the level of `start` selects the phase. While `start` is low, the surrounding logic owns the memory port. It writes words with `wr_init` and reads them back with `rd_en`, using `ext_addr` to pick the location. While `start` is high, an internal controller owns the port and runs a nested-loop exchange sort.

In the sort, an outer index `i` steps from 0 to k-2. For each `i`, register A takes the word at `i` and an inner index `j` starts at `i+1`. For every `j` up to k-1, register B takes the word at `j` and the comparator checks A against B. When A is greater than B, the block makes two writes: B goes to location `i`, then A goes to location `j`. It then reloads A from location `i`. When the last pair has been handled, `done` goes high and stays high until `start` is dropped. The block then returns to waiting for the next start.

The memory has k = 2^ADDR_W words of DATA_W bits. Writes happen on the clock edge and reads are combinational. The data interface uses plain strobes with no back-pressure: a write strobe always completes in its cycle, and a read strobe returns data in the same cycle. The caller must keep `start` high until `done` is seen.

Top module: `exchange_sorter`

## Requirements
- R1: An active-low `rst_n` forces `done` low and returns the controller to idle. It does not alter the words held in memory, so words written before a reset read back unchanged after it.
- R2: While `start` is low, `wr_init` high at a rising clock edge writes `wr_data` into location `ext_addr`. While `start` is low and `rd_en` is high, `rd_data` shows the word at `ext_addr` in the same cycle. `rd_data` is zero whenever `rd_en` is low.
- R3: When `done` goes high, memory holds the loaded words in ascending order, lowest value at address 0. In every comparison step the inner index is strictly greater than the outer index. A pair is swapped only when the A word is strictly greater than the B word.
- R4: Words are compared as unsigned numbers, so a word with its top bit set sorts above every word whose top bit is clear.
- R5: Equal words are never exchanged, and the sorted result holds exactly the same multiset of values as the loaded data, duplicates included.
- R6: `done` rises only while `start` is high and stays high as long as `start` stays high. It falls in the cycle after `start` is sampled low. A later rising `start` runs a fresh sort.
- R7: While `start` is high, `wr_init`, `wr_data` and `ext_addr` have no effect on memory, and `rd_data` stays zero even with `rd_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control and data registers |
| wr_data | input | DATA_W | Word written during the load phase |
| rd_data | output | DATA_W | Word read during the readout phase, zero otherwise |
| ext_addr | input | ADDR_W | External location for load and readout |
| wr_init | input | 1 | Load strobe, active while `start` is low |
| start | input | 1 | High requests a sort and hands the memory port to the controller |
| rd_en | input | 1 | Readout strobe, active while `start` is low |
| done | output | 1 | Sort complete, held until `start` falls |

## Verification
The bench builds the block with DATA_W = 8 and ADDR_W = 2, so k = 4. With k = 4 it can run all 24 orderings of four distinct words, which covers every swap pattern the nested loop can produce. An 8-bit word lets the top bit be set, which tests the unsigned ordering, and makes duplicate and already-sorted tables easy to build. Runs with random contents and directed tests for reset retention, the `done` handshake and port ownership while `start` is high complete the coverage.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD_A,
    ST_LOAD_B,
    ST_CMP,
    ST_WR_I,
    ST_WR_J,
    ST_RELOAD,
    ST_STEP,
    ST_DONE
  } sort_state_e;

  typedef struct packed {
    logic clr_i;   // outer index to zero
    logic inc_i;   // outer index step
    logic ld_j;    // inner index to i+1
    logic inc_j;   // inner index step
    logic en_a;    // capture memory word into A
    logic en_b;    // capture memory word into B
    logic sel_j;   // address from j, else from i
    logic sel_b;   // write data from B, else from A
    logic we;      // controller write
  } sort_ctl_t;

endpackage

// File: rtl/sorter_mem.sv
module sorter_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/sorter_datapath.sv
module sorter_datapath
  import sorter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_init,
  input  sort_ctl_t         ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] b_q,
  output logic [ADDR_W-1:0] i_q,
  output logic [ADDR_W-1:0] j_q,
  output logic              i_last,
  output logic              j_last,
  output logic              a_gt_b
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] I_END = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] J_END = ADDR_W'(DEPTH - 1);

  // outer index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         i_q <= '0;
    else if (ctl.clr_i) i_q <= '0;
    else if (ctl.inc_i) i_q <= i_q + 1'b1;
  end

  // inner index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         j_q <= '0;
    else if (ctl.ld_j)  j_q <= i_q + 1'b1;
    else if (ctl.inc_j) j_q <= j_q + 1'b1;
  end

  // operand registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (ctl.en_a) a_q <= mem_rdata;
      if (ctl.en_b) b_q <= mem_rdata;
    end
  end

  assign i_last = (i_q == I_END);
  assign j_last = (j_q == J_END);
  assign a_gt_b = (a_q > b_q);

  // port ownership follows the start level
  always_comb begin
    if (start) begin
      mem_addr  = ctl.sel_j ? j_q : i_q;
      mem_wdata = ctl.sel_b ? b_q : a_q;
      mem_we    = ctl.we;
    end else begin
      mem_addr  = ext_addr;
      mem_wdata = wr_data;
      mem_we    = wr_init;
    end
  end
endmodule

// File: rtl/sorter_ctrl.sv
module sorter_ctrl
  import sorter_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        i_last,
  input  logic        j_last,
  input  logic        a_gt_b,
  output sort_ctl_t   ctl,
  output sort_state_e st,
  output logic        done
);
  sort_state_e nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt = st;
    ctl = '0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          ctl.clr_i = 1'b1;
          nxt       = ST_LOAD_A;
        end
      end
      ST_LOAD_A: begin
        ctl.en_a = 1'b1;
        ctl.ld_j = 1'b1;
        nxt      = ST_LOAD_B;
      end
      ST_LOAD_B: begin
        ctl.sel_j = 1'b1;
        ctl.en_b  = 1'b1;
        nxt       = ST_CMP;
      end
      ST_CMP: begin
        nxt = a_gt_b ? ST_WR_I : ST_STEP;
      end
      ST_WR_I: begin
        ctl.sel_b = 1'b1;
        ctl.we    = 1'b1;
        nxt       = ST_WR_J;
      end
      ST_WR_J: begin
        ctl.sel_j = 1'b1;
        ctl.we    = 1'b1;
        nxt       = ST_RELOAD;
      end
      ST_RELOAD: begin
        ctl.en_a = 1'b1;
        nxt      = ST_STEP;
      end
      ST_STEP: begin
        if (!j_last) begin
          ctl.inc_j = 1'b1;
          nxt       = ST_LOAD_B;
        end else if (!i_last) begin
          ctl.inc_i = 1'b1;
          nxt       = ST_LOAD_A;
        end else begin
          nxt = ST_DONE;
        end
      end
      ST_DONE: begin
        if (!start) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign done = (st == ST_DONE);
endmodule

// File: rtl/exchange_sorter.sv
module exchange_sorter
  import sorter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              wr_init,
  input  logic              start,
  input  logic              rd_en,
  output logic              done
);
  sort_ctl_t         ctl;
  sort_state_e       st;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              mem_we;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;
  logic [ADDR_W-1:0] i_q;
  logic [ADDR_W-1:0] j_q;
  logic              i_last;
  logic              j_last;
  logic              a_gt_b;

  sorter_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .i_last (i_last),
    .j_last (j_last),
    .a_gt_b (a_gt_b),
    .ctl    (ctl),
    .st     (st),
    .done   (done)
  );

  sorter_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ext_addr  (ext_addr),
    .wr_data   (wr_data),
    .wr_init   (wr_init),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .a_q       (a_q),
    .b_q       (b_q),
    .i_q       (i_q),
    .j_q       (j_q),
    .i_last    (i_last),
    .j_last    (j_last),
    .a_gt_b    (a_gt_b)
  );

  sorter_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign rd_data = (rd_en && !start) ? mem_rdata : '0;
endmodule

// File: rtl/sorter_chk.sv
module sorter_chk
  import sorter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input sort_state_e       st,
  input logic [DATA_W-1:0] a_q,
  input logic [DATA_W-1:0] b_q,
  input logic [ADDR_W-1:0] i_q,
  input logic [ADDR_W-1:0] j_q
);
  // R3
  idx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD_B) |-> (j_q > i_q))
    else $error("inner index not above outer index");

  // R3
  swap_gt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR_J) |-> (a_q > b_q))
    else $error("exchange without A greater than B");

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done)
    else $error("done dropped while start high");

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done)
    else $error("done kept after start low");

  // R6
  done_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> start)
    else $error("done rose without start");
endmodule

bind exchange_sorter sorter_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .done  (done),
  .st    (st),
  .a_q   (a_q),
  .b_q   (b_q),
  .i_q   (i_q),
  .j_q   (j_q)
);

// File: tb/tb_exchange_sorter.sv
`timescale 1ns/1ps
module tb_exchange_sorter;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int K  = 1 << AW;
  localparam int NV = 8;

  typedef logic [DW-1:0] words_t [K];

  // stimulus table; expected result is its sorted form
  localparam logic [DW-1:0] VTAB [NV][K] = '{
    '{8'd3,   8'd2,   8'd4,   8'd1},
    '{8'd1,   8'd2,   8'd3,   8'd4},
    '{8'd9,   8'd7,   8'd4,   8'd0},
    '{8'd5,   8'd5,   8'd1,   8'd5},
    '{8'd6,   8'd6,   8'd6,   8'd6},
    '{8'hF0,  8'h01,  8'h80,  8'h7F},
    '{8'hFF,  8'h00,  8'hFF,  8'h00},
    '{8'd200, 8'd17,  8'd17,  8'd130}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] ext_addr = '0;
  logic          wr_init = 1'b0;
  logic          start = 1'b0;
  logic          rd_en = 1'b0;
  logic          done;

  int checks = 0;
  int errors = 0;
  words_t exp_w;

  always #4 clk = ~clk;

  exchange_sorter #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .rd_data(rd_data),
    .ext_addr(ext_addr), .wr_init(wr_init), .start(start),
    .rd_en(rd_en), .done(done)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input words_t v);
    for (int a = 0; a < K; a++) begin
      @(negedge clk);
      ext_addr = AW'(a);
      wr_data  = v[a];
      wr_init  = 1'b1;
    end
    @(negedge clk);
    wr_init = 1'b0;
  endtask

  task automatic ref_sort(input words_t v);
    exp_w = v;
    for (int p = 1; p < K; p++) begin
      for (int q = p; q > 0 && exp_w[q-1] > exp_w[q]; q--) begin
        logic [DW-1:0] t;
        t = exp_w[q];
        exp_w[q] = exp_w[q-1];
        exp_w[q-1] = t;
      end
    end
  endtask

  task automatic readback(input string req);
    for (int a = 0; a < K; a++) begin
      @(negedge clk);
      ext_addr = AW'(a);
      rd_en    = 1'b1;
      #1;
      check(req, rd_data, exp_w[a]);
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(req, DW'(done), DW'(1));
  endtask

  task automatic run_sort(input words_t v, input string req);
    load(v);
    ref_sort(v);
    @(negedge clk);
    start = 1'b1;
    wait_done("R6 done rises");
    @(negedge clk);
    @(negedge clk);
    check("R6 done held", DW'(done), DW'(1));
    start = 1'b0;
    @(negedge clk);
    check("R6 done falls", DW'(done), DW'(0));
    readback(req);
  endtask

  initial begin
    // R1 reset state
    #1;
    check("R1 done low in reset", DW'(done), DW'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done low after reset", DW'(done), DW'(0));
    check("R2 rd_data zero with rd_en low", rd_data, '0);

    // R2 load and readback without sort
    begin
      words_t w;
      w = '{8'h11, 8'h22, 8'h33, 8'h44};
      load(w);
      exp_w = w;
      readback("R2 readback");
    end

    // table walk: R3 order, R4 unsigned, R5 duplicates
    for (int r = 0; r < NV; r++) begin
      words_t v;
      for (int a = 0; a < K; a++) v[a] = VTAB[r][a];
      run_sort(v, (r == 5 || r == 6) ? "R4 unsigned order" :
                  (r == 3 || r == 4 || r == 7) ? "R5 duplicates" :
                  "R3 ascending");
    end

    // R3 every ordering of four distinct words
    for (int p0 = 0; p0 < K; p0++)
      for (int p1 = 0; p1 < K; p1++)
        for (int p2 = 0; p2 < K; p2++)
          for (int p3 = 0; p3 < K; p3++) begin
            if (p0 != p1 && p0 != p2 && p0 != p3 &&
                p1 != p2 && p1 != p3 && p2 != p3) begin
              words_t v;
              v = '{DW'(10 + 20*p0), DW'(10 + 20*p1),
                    DW'(10 + 20*p2), DW'(10 + 20*p3)};
              run_sort(v, "R3 permutation");
            end
          end

    // R5 random runs with narrow range for repeats
    for (int r = 0; r < 10; r++) begin
      words_t v;
      for (int a = 0; a < K; a++)
        v[a] = (r < 5) ? DW'($urandom_range(0, 3)) : DW'($urandom);
      run_sort(v, "R5 random");
    end

    // R7 external port ignored while start high
    begin
      words_t v;
      v = '{8'd40, 8'd30, 8'd20, 8'd10};
      load(v);
      ref_sort(v);
      @(negedge clk);
      start = 1'b1;
      wait_done("R6 done rises");
      ext_addr = '0;
      wr_data  = 8'hAA;
      wr_init  = 1'b1;
      rd_en    = 1'b1;
      #1;
      check("R7 rd_data zero while start high", rd_data, '0);
      @(negedge clk);
      wr_init = 1'b0;
      rd_en   = 1'b0;
      start   = 1'b0;
      @(negedge clk);
      readback("R7 memory untouched");
    end

    // R1 memory survives reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 done low in reset", DW'(done), DW'(0));
    @(negedge clk);
    rst_n = 1'b1;
    readback("R1 memory kept over reset");

    // R6 a fresh start after reset runs again
    begin
      words_t v;
      v = '{8'd8, 8'd1, 8'd8, 8'd0};
      run_sort(v, "R6 re-run");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule